// File: doc/BRIEF.md
# Packed-Decimal String Adder/Subtractor

This unit performs in-place decimal arithmetic on numbers stored as strings of packed-BCD bytes in an external scratch RAM with a one-cycle read latency. Every byte carries two decimal digits: the upper nibble is the tens digit and the lower nibble the units digit. A number of `span`+1 bytes begins at address `dst_ptr` and runs toward lower addresses. The byte at `dst_ptr` is the least significant one.

A one-cycle `start` pulse begins an operation that `op_sel` chooses. The second operand is one of two things: a second string of equal length whose least significant byte is at `src_ptr`, or the single byte `acc`. In the single-byte modes `acc` takes part only at the least significant byte. The carry or borrow then moves through the remaining bytes. The result overwrites the destination string. The unit reports the final carry or borrow and a zero indication. It raises `done` for one cycle when it finishes.

Top module: `bcd_string_alu`

## Requirements
- R1: With `op_sel`=2'b00, the destination string becomes its value plus `acc`. `acc` is added at the least significant byte and the carry moves upward through every higher byte of the string.
- R2: With `op_sel`=2'b01, `acc` is subtracted at the least significant byte and the borrow moves upward through the higher bytes. When a subtrahend plus the incoming borrow exceeds the minuend byte, the result byte is minuend+100-subtrahend-borrow and a borrow goes to the next byte.
- R3: With `op_sel`=2'b10, the string at `src_ptr`, `src_ptr`-1, … is added byte for byte to the string at `dst_ptr`, `dst_ptr`-1, … with a decimal carry between bytes.
- R4: With `op_sel`=2'b11, the source string is subtracted byte for byte from the destination string with a decimal borrow between bytes. The borrow follows the same rule as in R2.
- R5: Each byte is processed in order from address `dst_ptr` down to `dst_ptr`-`span`. The source byte that is read during a step is the one as it stands after all earlier steps.
- R6: When `done` is high, `carry_out` holds the carry out of the most significant byte (for an add) or the borrow out of it (for a subtract). `carry_out` and `zero_out` change only in the cycle in which `done` is high.
- R7: When `done` is high, `zero_out` is 1 exactly when every result byte written is 8'h00.
- R8: No RAM byte outside `dst_ptr`-`span` … `dst_ptr` is written. The source string is left unchanged unless it overlaps the destination.
- R9: `done` is high for exactly one cycle. It rises 3×(`span`+1) rising edges after the edge that accepts `start`. `ram_we` is never high in two consecutive cycles.
- R10: A `start` pulse that arrives while `busy` is high has no effect on the running operation: its result, its flags and its length are unchanged.
- R11: After reset, `busy`, `done`, `carry_out`, `zero_out` and `ram_we` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins an operation when the unit is idle |
| op_sel | input | 2 | bit0: subtract, bit1: string operand |
| dst_ptr | input | 7 | Address of the least significant destination byte |
| src_ptr | input | 7 | Address of the least significant source byte |
| span | input | 8 | Byte count minus one |
| acc | input | 8 | Single-byte BCD operand |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| carry_out | output | 1 | Final carry or borrow |
| zero_out | output | 1 | All result bytes zero |
| ram_addr | output | 7 | Scratch RAM address |
| ram_we | output | 1 | Scratch RAM write enable |
| ram_wdata | output | 8 | Scratch RAM write data |
| ram_rdata | input | 8 | Scratch RAM read data, one cycle after the address |

## Verification
A vector table runs all four operations on RAM images filled with different digit patterns. It uses lengths from one byte to ten bytes, string pairs that are far apart, adjacent or identical, and both small and large `acc` values. These runs separate correct carry and borrow movement from errors confined to a single byte. Directed cases drive every carry to the top, with all-99 strings plus one. They drive every borrow to the top, with all-zero strings minus one. They also subtract a string from itself to give an exact zero result, and use a single-byte length. These cases expose errors in the final flags and in the zero indication. A `start` pulse injected partway through an operation shows whether a busy unit accepts a second request.

// File: rtl/bcdu_pkg.sv
package bcdu_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RD_DST,
        PH_RD_SRC,
        PH_WR,
        PH_FIN
    } phase_e;

    typedef struct packed {
        logic string_mode;
        logic sub;
    } op_t;

    typedef struct packed {
        logic [7:0] bcd;
        logic       cout;
    } byte_res_t;

    function automatic op_t decode_op(input logic [1:0] sel);
        op_t o;
        o.string_mode = sel[1];
        o.sub         = sel[0];
        return o;
    endfunction

    function automatic logic [6:0] bcd_val(input logic [7:0] b);
        return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
    endfunction

    function automatic logic [7:0] val_bcd(input logic [6:0] v);
        logic [6:0] tens;
        logic [6:0] units;
        tens  = v / 7'd10;
        units = v - tens * 7'd10;
        return {tens[3:0], units[3:0]};
    endfunction

    function automatic logic digits_ok(input logic [7:0] b);
        return (b[7:4] <= 4'd9) && (b[3:0] <= 4'd9);
    endfunction

endpackage

// File: rtl/bcd_byte_alu.sv
module bcd_byte_alu
    import bcdu_pkg::*;
(
    input  logic       sub,
    input  logic [7:0] lhs,
    input  logic [7:0] rhs,
    input  logic       cin,
    output byte_res_t  res
);

    logic [7:0] lv;
    logic [7:0] rv;
    logic [7:0] sum;
    logic [7:0] need;
    logic [7:0] val;

    always_comb begin
        lv   = {1'b0, bcd_val(lhs)};
        rv   = {1'b0, bcd_val(rhs)};
        sum  = lv + rv + {7'd0, cin};
        need = rv + {7'd0, cin};
        if (!sub) begin
            res.cout = (sum >= 8'd100);
            val      = res.cout ? (sum - 8'd100) : sum;
        end else begin
            res.cout = (need > lv);
            val      = res.cout ? (lv + 8'd100 - need) : (lv - need);
        end
        res.bcd = val_bcd(val[6:0]);
    end

endmodule

// File: rtl/bcd_seq_ctrl.sv
module bcd_seq_ctrl
    import bcdu_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] dst_ptr,
    input  logic [ADDR_W-1:0] src_ptr,
    input  logic [LEN_W-1:0]  span,
    output phase_e            phase,
    output logic [ADDR_W-1:0] addr,
    output logic              accept,
    output logic              first_byte,
    output logic              last_byte
);

    localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(1);
    localparam logic [LEN_W-1:0]  LEN_STEP  = LEN_W'(1);

    logic [ADDR_W-1:0] dst_cur;
    logic [ADDR_W-1:0] src_cur;
    logic [LEN_W-1:0]  remain;
    logic              first_q;

    assign accept     = start && (phase == PH_IDLE);
    assign first_byte = first_q;
    assign last_byte  = (remain == '0);
    assign addr       = (phase == PH_RD_SRC) ? src_cur : dst_cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            dst_cur <= '0;
            src_cur <= '0;
            remain  <= '0;
            first_q <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase   <= PH_RD_DST;
                        dst_cur <= dst_ptr;
                        src_cur <= src_ptr;
                        remain  <= span;
                        first_q <= 1'b1;
                    end
                end
                PH_RD_DST: phase <= PH_RD_SRC;
                PH_RD_SRC: phase <= PH_WR;
                PH_WR: begin
                    if (remain == '0) begin
                        phase <= PH_FIN;
                    end else begin
                        phase   <= PH_RD_DST;
                        remain  <= remain - LEN_STEP;
                        dst_cur <= dst_cur - ADDR_STEP;
                        src_cur <= src_cur - ADDR_STEP;
                        first_q <= 1'b0;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R5
    step_order_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RD_SRC) |-> ($past(phase) == PH_RD_DST));

    // R10
    hold_base_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RD_SRC) |-> $stable(dst_cur));

endmodule

// File: rtl/bcd_string_alu.sv
module bcd_string_alu
    import bcdu_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        op_sel,
    input  logic [ADDR_W-1:0] dst_ptr,
    input  logic [ADDR_W-1:0] src_ptr,
    input  logic [LEN_W-1:0]  span,
    input  logic [7:0]        acc,
    output logic              busy,
    output logic              done,
    output logic              carry_out,
    output logic              zero_out,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_we,
    output logic [7:0]        ram_wdata,
    input  logic [7:0]        ram_rdata
);

    phase_e     phase;
    logic       accept;
    logic       first_byte;
    logic       last_byte;
    op_t        op_q;
    logic [7:0] acc_q;
    logic [7:0] dst_byte;
    logic [7:0] rhs;
    logic       chain_q;
    logic       zacc_q;
    byte_res_t  res;

    bcd_seq_ctrl #(
        .ADDR_W(ADDR_W),
        .LEN_W (LEN_W)
    ) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .dst_ptr   (dst_ptr),
        .src_ptr   (src_ptr),
        .span      (span),
        .phase     (phase),
        .addr      (ram_addr),
        .accept    (accept),
        .first_byte(first_byte),
        .last_byte (last_byte)
    );

    always_comb begin
        if (op_q.string_mode) rhs = ram_rdata;
        else if (first_byte)  rhs = acc_q;
        else                  rhs = 8'h00;
    end

    bcd_byte_alu alu_i (
        .sub(op_q.sub),
        .lhs(dst_byte),
        .rhs(rhs),
        .cin(chain_q),
        .res(res)
    );

    assign busy      = (phase != PH_IDLE);
    assign done      = (phase == PH_FIN);
    assign ram_we    = (phase == PH_WR);
    assign ram_wdata = res.bcd;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q      <= '0;
            acc_q     <= '0;
            dst_byte  <= '0;
            chain_q   <= 1'b0;
            zacc_q    <= 1'b1;
            carry_out <= 1'b0;
            zero_out  <= 1'b0;
        end else begin
            if (accept) begin
                op_q    <= decode_op(op_sel);
                acc_q   <= acc;
                chain_q <= 1'b0;
                zacc_q  <= 1'b1;
            end
            if (phase == PH_RD_SRC) dst_byte <= ram_rdata;
            if (phase == PH_WR) begin
                chain_q <= res.cout;
                zacc_q  <= zacc_q && (res.bcd == 8'h00);
                if (last_byte) begin
                    carry_out <= res.cout;
                    zero_out  <= zacc_q && (res.bcd == 8'h00);
                end
            end
        end
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    we_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        ram_we |=> !ram_we);

    // R10
    busy_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R6
    flag_update_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable({carry_out, zero_out}) |-> done);

    // R1
    digit_range_chk: assert property (@(posedge clk) disable iff (rst)
        (ram_we && digits_ok(dst_byte) && digits_ok(rhs)) |-> digits_ok(ram_wdata));

    // R7
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (done && zero_out) |-> ($past(ram_wdata) == 8'h00));

endmodule

// File: tb/bcd_string_alu_tb_top.sv
`timescale 1ns/1ps
module bcd_string_alu_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [1:0] op = 2'b00;
    logic [6:0] dp = '0;
    logic [6:0] sp = '0;
    logic [7:0] span = '0;
    logic [7:0] acc = '0;
    logic       busy, done, c_o, z_o, ram_we;
    logic [6:0] ram_addr;
    logic [7:0] ram_wdata;
    logic [7:0] ram_rdata = '0;

    logic       tb_we = 1'b0;
    logic [6:0] tb_addr = '0;
    logic [7:0] tb_data = '0;
    logic [7:0] mem   [0:127];
    logic [7:0] img   [0:127];
    logic [7:0] exp_m [0:127];

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    bcd_string_alu dut_i (
        .clk(clk), .rst(rst), .start(start), .op_sel(op),
        .dst_ptr(dp), .src_ptr(sp), .span(span), .acc(acc),
        .busy(busy), .done(done), .carry_out(c_o), .zero_out(z_o),
        .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata)
    );

    always @(posedge clk) begin
        if (ram_we)     mem[ram_addr] <= ram_wdata;
        else if (tb_we) mem[tb_addr]  <= tb_data;
        ram_rdata <= mem[ram_addr];
    end

    // op(2) dst(7) src(7) span(8) acc(8) seed(8)
    localparam int NV = 10;
    localparam logic [39:0] VEC [NV] = '{
        {2'd0, 7'd40, 7'd0,  8'd3, 8'h57, 8'd13},
        {2'd0, 7'd20, 7'd0,  8'd0, 8'h99, 8'd31},
        {2'd1, 7'd50, 7'd0,  8'd4, 8'h73, 8'd7},
        {2'd1, 7'd9,  7'd0,  8'd9, 8'h01, 8'd3},
        {2'd2, 7'd60, 7'd30, 8'd5, 8'h00, 8'd17},
        {2'd2, 7'd95, 7'd80, 8'd7, 8'h00, 8'd29},
        {2'd3, 7'd70, 7'd40, 8'd3, 8'h00, 8'd11},
        {2'd3, 7'd33, 7'd34, 8'd2, 8'h00, 8'd43},
        {2'd2, 7'd12, 7'd12, 8'd4, 8'h00, 8'd9},
        {2'd3, 7'd25, 7'd25, 8'd2, 8'h00, 8'd21}
    };

    function automatic int dec_of(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] enc_of(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic string req_of(input logic [1:0] o);
        case (o)
            2'd0:    return "R1";
            2'd1:    return "R2";
            2'd2:    return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic fill(input int seed);
        for (int k = 0; k < 128; k++) img[k] = enc_of((k * seed + 7) % 100);
    endtask

    task automatic load_ram();
        for (int k = 0; k < 128; k++) begin
            @(negedge clk);
            tb_we = 1'b1; tb_addr = 7'(k); tb_data = img[k];
        end
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic model(input logic [1:0] o, input int p, input int q,
                         input int n, input logic [7:0] a,
                         output bit ec, output bit ez);
        int cy, pv, ov, s, t, pa;
        for (int k = 0; k < 128; k++) exp_m[k] = img[k];
        cy = 0; ez = 1'b1;
        for (int k = 0; k <= n; k++) begin
            pa = (p - k) & 127;
            pv = dec_of(exp_m[pa]);
            if (o[1]) ov = dec_of(exp_m[(q - k) & 127]);
            else      ov = (k == 0) ? dec_of(a) : 0;
            if (!o[0]) begin
                s  = pv + ov + cy;
                cy = (s >= 100) ? 1 : 0;
                if (cy == 1) s = s - 100;
            end else begin
                t  = ov + cy;
                cy = (t > pv) ? 1 : 0;
                s  = (cy == 1) ? pv + 100 - t : pv - t;
            end
            exp_m[pa] = enc_of(s);
            if (s != 0) ez = 1'b0;
        end
        ec = (cy == 1);
    endtask

    task automatic run_case(input logic [1:0] o, input int p, input int q,
                            input int n, input logic [7:0] a, input int poke);
        bit ec, ez;
        int cycles, bad, first_bad;
        string rq;
        rq = req_of(o);
        model(o, p, q, n, a, ec, ez);
        load_ram();
        @(negedge clk);
        op = o; dp = 7'(p); sp = 7'(q); span = 8'(n); acc = a; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cycles = 0;
        while (cycles < 5000) begin
            @(posedge clk);
            cycles++;
            @(negedge clk);
            start = 1'b0;
            if (done) break;
            if (cycles == poke) begin
                // R10: a second request while busy
                start = 1'b1; op = ~o; span = 8'd0; acc = 8'h55; sp = 7'(q + 1);
            end
        end
        chk(cycles == 3 * (n + 1), "R9", "cycles to done", cycles, 3 * (n + 1));
        chk(c_o == ec, rq, "R6 final carry/borrow", int'(c_o), int'(ec));
        chk(z_o == ez, rq, "R7 zero flag", int'(z_o), int'(ez));
        bad = 0; first_bad = -1;
        for (int k = 0; k < 128; k++)
            if (mem[k] !== exp_m[k]) begin
                bad++;
                if (first_bad < 0) first_bad = k;
            end
        if (first_bad < 0)
            chk(1'b1, rq, "R8 R5 RAM image", 0, 0);
        else
            chk(1'b0, rq, "R8 R5 RAM byte value", int'(mem[first_bad]), int'(exp_m[first_bad]));
        @(negedge clk);
        chk(!done && !busy, "R9", "done width/busy after done", int'({done, busy}), 0);
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk({busy, done, c_o, z_o, ram_we} == 5'b0, "R11", "reset outputs",
            int'({busy, done, c_o, z_o, ram_we}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk({busy, done, ram_we} == 3'b0, "R11", "idle after reset",
            int'({busy, done, ram_we}), 0);

        for (int v = 0; v < NV; v++) begin
            fill(int'(VEC[v][7:0]));
            run_case(VEC[v][39:38], int'(VEC[v][37:31]), int'(VEC[v][30:24]),
                     int'(VEC[v][23:16]), VEC[v][15:8], -1);
        end

        // R1: all-99 plus one carries to the top, C=1, Z=1
        fill(5);
        for (int k = 7; k <= 10; k++) img[k] = 8'h99;
        run_case(2'd0, 10, 0, 3, 8'h01, -1);

        // R2: all-zero minus one borrows to the top, C=1
        fill(6);
        for (int k = 30; k <= 35; k++) img[k] = 8'h00;
        run_case(2'd1, 35, 0, 5, 8'h01, -1);

        // R4: string minus identical copy gives zero, C=0, Z=1
        fill(8);
        for (int k = 0; k < 4; k++) img[50 + k] = img[60 + k];
        run_case(2'd3, 63, 53, 3, 8'h00, -1);

        // R1: single byte 45+55 -> 00 with carry
        fill(12);
        img[77] = 8'h45;
        run_case(2'd0, 77, 0, 0, 8'h55, -1);

        // R10: start while busy ignored
        fill(19);
        run_case(2'd2, 45, 20, 4, 8'h00, 5);
        fill(23);
        run_case(2'd1, 90, 0, 6, 8'h38, 10);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule